// File: doc/BRIEF.md
# Memory Banking Configuration Registers

This block is a small register file that a processor reads and writes over a simple synchronous bus. It holds the live memory-banking configuration byte and drives it, with its fields split out, to the downstream address decoder. It also holds four stored preset configurations, a mode byte, a RAM-sharing configuration byte, a read-only version byte and the storage for two relocatable page pointers.

The block decodes two address windows. The full window, at `FULL_BASE`, exposes every register. The alias window, at `ALIAS_BASE`, sits at the top of the address space and stays mapped whatever the banking selects. Its offset 0 is a second path to the live configuration. Its offsets 1 to 4 are load strobes. Any write to a load strobe copies one preset into the live configuration in a single bus access, so software can switch between prepared banking setups without first mapping I/O space in.

Every write completes on the clock edge that samples it, and the registered outputs show the new value from the next cycle. Reads are combinational from the address.

Top module: `bank_cfg_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, the live configuration, all four presets, the mode byte, the RAM configuration byte and all four page-pointer bytes are 0x00. With a live value of zero, every region selects system ROM and system I/O stays visible.
- R2: A write to full-window offset 0x0 or alias-window offset 0x0 loads `bus_wdata` into the live configuration. `cfg_byte` shows the new value in the cycle after the write edge.
- R3: A write to full-window offset 0x1, 0x2, 0x3 or 0x4 stores the data in preset 0, 1, 2 or 3 respectively and leaves `cfg_byte` unchanged.
- R4: A write to alias-window offset 0x1 to 0x4 copies preset 0 to 3 into the live configuration, with the result on `cfg_byte` in the next cycle. The written data is ignored and the preset itself is not changed.
- R5: The field outputs decode the live byte. `cfg_ram_bank` is bit 6, `cfg_rom_hi` is bits 5:4, `cfg_rom_mid` is bits 3:2, `cfg_rom_lo` is bit 1 and `cfg_io_sel` is bit 0. Bit 7 is reserved but is stored and read back as written.
- R6: Full-window offsets 0x5 (mode), 0x6 (RAM configuration), 0x7/0x8 (page-0 low/high) and 0x9/0xA (page-1 low/high) read back what was last written to them. `mode_cfg` and `ram_cfg` output the mode and RAM configuration bytes. `page0_ptr` and `page1_ptr` output {high, low} of their byte pairs.
- R7: Full-window offset 0xB reads the `VERSION` parameter, and writes to it have no effect.
- R8: Alias offset 0x0 reads the live configuration and alias offsets 0x1 to 0x4 read presets 0 to 3. Reads of full-window offsets 0xC to 0xF, alias offsets 0x5 to 0xF and any address outside both windows return 0xFF.
- R9: A bus cycle with `bus_we` low, or a write to an unmapped address or to the version offset, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_data | output | 8 | Read data for `bus_addr`, combinational |
| cfg_byte | output | 8 | Live banking configuration byte |
| cfg_ram_bank | output | 1 | RAM bank select field |
| cfg_rom_hi | output | 2 | High ROM region select field |
| cfg_rom_mid | output | 2 | Mid ROM region select field |
| cfg_rom_lo | output | 1 | Low ROM region select field |
| cfg_io_sel | output | 1 | I/O region select field |
| mode_cfg | output | 8 | Mode byte |
| ram_cfg | output | 8 | RAM-sharing configuration byte |
| page0_ptr | output | 16 | Page-0 pointer {high, low} |
| page1_ptr | output | 16 | Page-1 pointer {high, low} |

## Verification
The bound checker watches, on every cycle, the live-byte effects of direct writes and of load strobes, the fact that preset writes and idle cycles leave the live byte steady, the value returned at the version offset, the 0xFF returned outside both windows, and the zero value held during reset. Only the bench scenarios can show that presets are kept correctly across several loads, that load-strobe data really is ignored, that page bytes pair up into the right pointer halves, and that writes to unmapped and read-only locations leave every register alone. The bench's behavioural model is compared against all outputs on every clock.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int OFF_W      = 4;
  localparam int NUM_PRESET = 4;
  localparam int NUM_PG     = 4;

  localparam logic [OFF_W-1:0] OFF_LIVE   = 4'h0;
  localparam logic [OFF_W-1:0] OFF_PRE0   = 4'h1;
  localparam logic [OFF_W-1:0] OFF_MODE   = 4'h5;
  localparam logic [OFF_W-1:0] OFF_RAMCFG = 4'h6;
  localparam logic [OFF_W-1:0] OFF_PG0    = 4'h7;
  localparam logic [OFF_W-1:0] OFF_VER    = 4'hB;

  typedef struct packed {
    logic       rsv;
    logic       ram_bank;
    logic [1:0] rom_hi;
    logic [1:0] rom_mid;
    logic       rom_lo;
    logic       io_sel;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LIVE,
    RD_PRE,
    RD_MODE,
    RD_RAM,
    RD_PG,
    RD_VER
  } rd_kind_e;

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] FULL_BASE  = 16'hD500,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'hFF00
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic                  wr_live,
  output logic [NUM_PRESET-1:0] wr_pre,
  output logic [NUM_PRESET-1:0] ld_pre,
  output logic                  wr_mode,
  output logic                  wr_ram,
  output logic [NUM_PG-1:0]     wr_pg,
  output rd_kind_e              rd_kind,
  output logic [1:0]            rd_idx
);

  localparam int TAG_W = ADDR_W - OFF_W;

  logic             full_hit;
  logic             alias_hit;
  logic [OFF_W-1:0] off;

  assign off       = addr[OFF_W-1:0];
  assign full_hit  = (addr[ADDR_W-1:OFF_W] == FULL_BASE[ADDR_W-1:OFF_W]);
  assign alias_hit = (addr[ADDR_W-1:OFF_W] == ALIAS_BASE[ADDR_W-1:OFF_W]);

  assign wr_live = we & (full_hit | alias_hit) & (off == OFF_LIVE);
  assign wr_mode = we & full_hit & (off == OFF_MODE);
  assign wr_ram  = we & full_hit & (off == OFF_RAMCFG);

  for (genvar i = 0; i < NUM_PRESET; i++) begin : g_pre
    localparam logic [OFF_W-1:0] OFF_I = OFF_W'(int'(OFF_PRE0) + i);
    assign wr_pre[i] = we & full_hit  & (off == OFF_I);
    assign ld_pre[i] = we & alias_hit & (off == OFF_I);
  end

  for (genvar j = 0; j < NUM_PG; j++) begin : g_pg
    localparam logic [OFF_W-1:0] OFF_J = OFF_W'(int'(OFF_PG0) + j);
    assign wr_pg[j] = we & full_hit & (off == OFF_J);
  end

  always_comb begin
    rd_kind = RD_NONE;
    rd_idx  = 2'd0;
    if (full_hit) begin
      if (off == OFF_LIVE) begin
        rd_kind = RD_LIVE;
      end else if (off >= OFF_PRE0 && off < OFF_MODE) begin
        rd_kind = RD_PRE;
        rd_idx  = 2'(off - OFF_PRE0);
      end else if (off == OFF_MODE) begin
        rd_kind = RD_MODE;
      end else if (off == OFF_RAMCFG) begin
        rd_kind = RD_RAM;
      end else if (off >= OFF_PG0 && off < OFF_VER) begin
        rd_kind = RD_PG;
        rd_idx  = 2'(off - OFF_PG0);
      end else if (off == OFF_VER) begin
        rd_kind = RD_VER;
      end
    end else if (alias_hit) begin
      if (off == OFF_LIVE) begin
        rd_kind = RD_LIVE;
      end else if (off >= OFF_PRE0 && off < OFF_MODE) begin
        rd_kind = RD_PRE;
        rd_idx  = 2'(off - OFF_PRE0);
      end
    end
  end

  logic unused_tag;
  assign unused_tag = ^{TAG_W{1'b0}};

endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  wdata,
  input  logic                        wr_live,
  input  logic [NUM_PRESET-1:0]       wr_pre,
  input  logic [NUM_PRESET-1:0]       ld_pre,
  input  logic                        wr_mode,
  input  logic                        wr_ram,
  input  logic [NUM_PG-1:0]           wr_pg,
  output logic [7:0]                  live_q,
  output logic [NUM_PRESET-1:0][7:0]  pre_q,
  output logic [7:0]                  mode_q,
  output logic [7:0]                  ram_q,
  output logic [NUM_PG-1:0][7:0]      pg_q
);

  // live configuration: direct write has priority over a load strobe
  logic       live_en;
  logic [7:0] live_d;

  always_comb begin
    live_en = wr_live | (|ld_pre);
    live_d  = live_q;
    if (wr_live) begin
      live_d = wdata;
    end else begin
      for (int k = 0; k < NUM_PRESET; k++) begin
        if (ld_pre[k]) live_d = pre_q[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  for (genvar i = 0; i < NUM_PRESET; i++) begin : g_pre
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q[i] <= '0;
      else if (wr_pre[i]) pre_q[i] <= wdata;
    end
  end

  for (genvar j = 0; j < NUM_PG; j++) begin : g_pg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pg_q[j] <= '0;
      else if (wr_pg[j]) pg_q[j] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ram_q <= '0;
    else if (wr_ram) ram_q <= wdata;
  end

endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
  import bcr_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h05
) (
  input  rd_kind_e                    rd_kind,
  input  logic [1:0]                  rd_idx,
  input  logic [7:0]                  live_q,
  input  logic [NUM_PRESET-1:0][7:0]  pre_q,
  input  logic [7:0]                  mode_q,
  input  logic [7:0]                  ram_q,
  input  logic [NUM_PG-1:0][7:0]      pg_q,
  output logic [7:0]                  rd_data
);

  always_comb begin
    unique case (rd_kind)
      RD_LIVE: rd_data = live_q;
      RD_PRE:  rd_data = pre_q[rd_idx];
      RD_MODE: rd_data = mode_q;
      RD_RAM:  rd_data = ram_q;
      RD_PG:   rd_data = pg_q[rd_idx];
      RD_VER:  rd_data = VERSION;
      default: rd_data = 8'hFF;
    endcase
  end

endmodule

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bcr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] FULL_BASE  = 16'hD500,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'hFF00,
  parameter logic [7:0]        VERSION    = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        rd_data,
  output logic [7:0]        cfg_byte,
  output logic              cfg_ram_bank,
  output logic [1:0]        cfg_rom_hi,
  output logic [1:0]        cfg_rom_mid,
  output logic              cfg_rom_lo,
  output logic              cfg_io_sel,
  output logic [7:0]        mode_cfg,
  output logic [7:0]        ram_cfg,
  output logic [15:0]       page0_ptr,
  output logic [15:0]       page1_ptr
);

  logic                       wr_live;
  logic [NUM_PRESET-1:0]      wr_pre;
  logic [NUM_PRESET-1:0]      ld_pre;
  logic                       wr_mode;
  logic                       wr_ram;
  logic [NUM_PG-1:0]          wr_pg;
  rd_kind_e                   rd_kind;
  logic [1:0]                 rd_idx;
  logic [7:0]                 live_q;
  logic [NUM_PRESET-1:0][7:0] pre_q;
  logic [7:0]                 mode_q;
  logic [7:0]                 ram_q;
  logic [NUM_PG-1:0][7:0]     pg_q;
  bank_cfg_t                  live_f;

  bcr_decode #(
    .ADDR_W    (ADDR_W),
    .FULL_BASE (FULL_BASE),
    .ALIAS_BASE(ALIAS_BASE)
  ) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .wr_live(wr_live),
    .wr_pre (wr_pre),
    .ld_pre (ld_pre),
    .wr_mode(wr_mode),
    .wr_ram (wr_ram),
    .wr_pg  (wr_pg),
    .rd_kind(rd_kind),
    .rd_idx (rd_idx)
  );

  bcr_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wdata  (bus_wdata),
    .wr_live(wr_live),
    .wr_pre (wr_pre),
    .ld_pre (ld_pre),
    .wr_mode(wr_mode),
    .wr_ram (wr_ram),
    .wr_pg  (wr_pg),
    .live_q (live_q),
    .pre_q  (pre_q),
    .mode_q (mode_q),
    .ram_q  (ram_q),
    .pg_q   (pg_q)
  );

  bcr_rdmux #(
    .VERSION(VERSION)
  ) u_rdmux (
    .rd_kind(rd_kind),
    .rd_idx (rd_idx),
    .live_q (live_q),
    .pre_q  (pre_q),
    .mode_q (mode_q),
    .ram_q  (ram_q),
    .pg_q   (pg_q),
    .rd_data(rd_data)
  );

  assign live_f       = bank_cfg_t'(live_q);
  assign cfg_byte     = live_q;
  assign cfg_ram_bank = live_f.ram_bank;
  assign cfg_rom_hi   = live_f.rom_hi;
  assign cfg_rom_mid  = live_f.rom_mid;
  assign cfg_rom_lo   = live_f.rom_lo;
  assign cfg_io_sel   = live_f.io_sel;
  assign mode_cfg     = mode_q;
  assign ram_cfg      = ram_q;
  assign page0_ptr    = {pg_q[1], pg_q[0]};
  assign page1_ptr    = {pg_q[3], pg_q[2]};

endmodule

// File: rtl/bank_cfg_regs_chk.sv
module bank_cfg_regs_chk
  import bcr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] FULL_BASE  = 16'hD500,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'hFF00,
  parameter logic [7:0]        VERSION    = 8'h05
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [7:0]                 bus_wdata,
  input logic                       bus_we,
  input logic [7:0]                 rd_data,
  input logic [7:0]                 cfg_byte,
  input logic [NUM_PRESET-1:0][7:0] pre_q
);

  logic full_hit;
  logic alias_hit;
  logic [OFF_W-1:0] off;

  assign off       = bus_addr[OFF_W-1:0];
  assign full_hit  = (bus_addr[ADDR_W-1:OFF_W] == FULL_BASE[ADDR_W-1:OFF_W]);
  assign alias_hit = (bus_addr[ADDR_W-1:OFF_W] == ALIAS_BASE[ADDR_W-1:OFF_W]);

  // R1: live byte held at zero while reset is asserted
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (cfg_byte == 8'h00);
    end
  end

  p_live_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (full_hit || alias_hit) && off == OFF_LIVE)
      |=> cfg_byte == $past(bus_wdata));

  p_preset_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && full_hit && off >= OFF_PRE0 && off < OFF_MODE)
      |=> $stable(cfg_byte));

  for (genvar i = 0; i < NUM_PRESET; i++) begin : g_ld
    localparam logic [OFF_W-1:0] OFF_I = OFF_W'(int'(OFF_PRE0) + i);
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && alias_hit && off == OFF_I)
        |=> cfg_byte == $past(pre_q[i]));
  end

  p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hit && off == OFF_VER) |-> rd_data == VERSION);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_hit && !alias_hit) |-> rd_data == 8'hFF);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(cfg_byte));

endmodule

bind bank_cfg_regs bank_cfg_regs_chk #(
  .ADDR_W    (ADDR_W),
  .FULL_BASE (FULL_BASE),
  .ALIAS_BASE(ALIAS_BASE),
  .VERSION   (VERSION)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .rd_data  (rd_data),
  .cfg_byte (cfg_byte),
  .pre_q    (pre_q)
);

// File: tb/bank_cfg_regs_bench.sv
module bank_cfg_regs_bench;

  localparam logic [7:0] VER = 8'h05;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  rd_data;
  logic [7:0]  cfg_byte;
  logic        cfg_ram_bank;
  logic [1:0]  cfg_rom_hi;
  logic [1:0]  cfg_rom_mid;
  logic        cfg_rom_lo;
  logic        cfg_io_sel;
  logic [7:0]  mode_cfg;
  logic [7:0]  ram_cfg;
  logic [15:0] page0_ptr;
  logic [15:0] page1_ptr;

  bank_cfg_regs #(
    .ADDR_W(16), .FULL_BASE(16'hD500), .ALIAS_BASE(16'hFF00), .VERSION(VER)
  ) u_bank_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .rd_data(rd_data), .cfg_byte(cfg_byte),
    .cfg_ram_bank(cfg_ram_bank), .cfg_rom_hi(cfg_rom_hi),
    .cfg_rom_mid(cfg_rom_mid), .cfg_rom_lo(cfg_rom_lo),
    .cfg_io_sel(cfg_io_sel), .mode_cfg(mode_cfg), .ram_cfg(ram_cfg),
    .page0_ptr(page0_ptr), .page1_ptr(page1_ptr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference model
  logic [7:0] m_live;
  logic [7:0] m_pre [4];
  logic [7:0] m_mode;
  logic [7:0] m_ram;
  logic [7:0] m_pg [4];

  task automatic model_reset();
    m_live = 8'h00; m_mode = 8'h00; m_ram = 8'h00;
    for (int i = 0; i < 4; i++) begin m_pre[i] = 8'h00; m_pg[i] = 8'h00; end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int o;
    o = int'(a[3:0]);
    if (a[15:4] == 12'hD50) begin
      if (o == 0) m_live = d;
      else if (o <= 4) m_pre[o-1] = d;
      else if (o == 5) m_mode = d;
      else if (o == 6) m_ram = d;
      else if (o <= 10) m_pg[o-7] = d;
    end else if (a[15:4] == 12'hFF0) begin
      if (o == 0) m_live = d;
      else if (o <= 4) m_live = m_pre[o-1];
    end
  endtask

  function automatic logic [7:0] model_read(input logic [15:0] a);
    int o;
    o = int'(a[3:0]);
    if (a[15:4] == 12'hD50) begin
      if (o == 0) return m_live;
      if (o <= 4) return m_pre[o-1];
      if (o == 5) return m_mode;
      if (o == 6) return m_ram;
      if (o <= 10) return m_pg[o-7];
      if (o == 11) return VER;
      return 8'hFF;
    end
    if (a[15:4] == 12'hFF0) begin
      if (o == 0) return m_live;
      if (o <= 4) return m_pre[o-1];
    end
    return 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of every output against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R3/R4 live config", {8'h00, cfg_byte}, {8'h00, m_live});
      check("R5 field decode",
            {11'h0, cfg_ram_bank, cfg_rom_hi, cfg_rom_mid, cfg_rom_lo, cfg_io_sel},
            {11'h0, m_live[6], m_live[5:4], m_live[3:2], m_live[1], m_live[0]});
      check("R6 mode/ram outputs", {mode_cfg, ram_cfg}, {m_mode, m_ram});
      check("R6 page0 pointer", page0_ptr, {m_pg[1], m_pg[0]});
      check("R6 page1 pointer", page1_ptr, {m_pg[3], m_pg[2]});
    end
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                        input string tag);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    if (!we) check(tag, {8'h00, rd_data}, {8'h00, model_read(a)});
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int o = 0; o < 16; o++) access(1'b0, 16'hD500 + 16'(o), 8'h00, tag);
    for (int o = 0; o < 16; o++) access(1'b0, 16'hFF00 + 16'(o), 8'h00, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    bus_we = 1'b0; bus_addr = 16'h0000; bus_wdata = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset live", {8'h00, cfg_byte}, 16'h0000);
    check("R1 reset pages", {page0_ptr ^ page1_ptr}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 registers zero after reset");

    // R2: direct live writes through both windows
    access(1'b1, 16'hD500, 8'h35, "R2");
    access(1'b0, 16'hFF00, 8'h00, "R8 alias reads live");
    access(1'b1, 16'hFF00, 8'hCA, "R2");
    access(1'b0, 16'hD500, 8'h00, "R2 full window reads live");

    // R3: presets store only
    access(1'b1, 16'hD501, 8'h3F, "R3");
    access(1'b1, 16'hD502, 8'h7E, "R3");
    access(1'b1, 16'hD503, 8'h01, "R3");
    access(1'b1, 16'hD504, 8'hB2, "R3");
    check("R3 live unchanged", {8'h00, cfg_byte}, 16'h00CA);
    read_all("R3/R8 preset readback");

    // R4: load strobes, data ignored, presets kept
    access(1'b1, 16'hFF02, 8'h00, "R4");
    check("R4 load preset1", {8'h00, cfg_byte}, 16'h007E);
    access(1'b1, 16'hFF04, 8'h5A, "R4");
    check("R4 load preset3 data ignored", {8'h00, cfg_byte}, 16'h00B2);
    access(1'b1, 16'hFF01, 8'hFF, "R4");
    check("R4 load preset0", {8'h00, cfg_byte}, 16'h003F);
    access(1'b1, 16'hFF03, 8'h80, "R4");
    check("R4 load preset2", {8'h00, cfg_byte}, 16'h0001);
    read_all("R4 presets unchanged after loads");

    // R5: sweep of field patterns
    for (int v = 0; v < 256; v += 37) access(1'b1, 16'hD500, 8'(v), "R5");

    // R6: remaining registers
    access(1'b1, 16'hD505, 8'h9C, "R6");
    access(1'b1, 16'hD506, 8'h0B, "R6");
    access(1'b1, 16'hD508, 8'h01, "R6");
    access(1'b1, 16'hD507, 8'h2E, "R6");
    access(1'b1, 16'hD50A, 8'h00, "R6");
    access(1'b1, 16'hD509, 8'hC4, "R6");
    check("R6 page0 value", page0_ptr, 16'h012E);
    check("R6 page1 value", page1_ptr, 16'h00C4);
    read_all("R6 readback");

    // R7: version is read-only
    access(1'b1, 16'hD50B, 8'h77, "R7");
    access(1'b0, 16'hD50B, 8'h00, "R7 version read");

    // R8: unmapped reads
    access(1'b0, 16'hD50C, 8'h00, "R8");
    access(1'b0, 16'hD50F, 8'h00, "R8");
    access(1'b0, 16'hFF05, 8'h00, "R8");
    access(1'b0, 16'hFF0F, 8'h00, "R8");
    access(1'b0, 16'h1234, 8'h00, "R8");
    access(1'b0, 16'hD4FF, 8'h00, "R8");
    access(1'b0, 16'hFF10, 8'h00, "R8");

    // R9: writes that must change nothing
    access(1'b1, 16'hD50D, 8'h11, "R9");
    access(1'b1, 16'hFF06, 8'h22, "R9");
    access(1'b1, 16'h0000, 8'h33, "R9");
    access(1'b1, 16'hD510, 8'h44, "R9");
    access(1'b1, 16'hFF11, 8'h55, "R9");
    bus_wdata = 8'hEE; bus_addr = 16'hD500; bus_we = 1'b0;
    @(negedge clk);
    check("R9 we low no change", {8'h00, cfg_byte}, {8'h00, m_live});
    read_all("R9 registers intact");

    // preset reload after live overwrite
    access(1'b1, 16'hFF00, 8'h00, "R2");
    access(1'b1, 16'hFF04, 8'h00, "R4");
    check("R4 reload preset3", {8'h00, cfg_byte}, 16'h00B2);

    finish_run();
  end

endmodule